// File: doc/BRIEF.md
# Packet-Granular Round-Robin Scanner Dispatcher

This block sits in front of a bank of byte-serial content scanners, by default four of them. Words arrive 32 bits per clock, but each scanner consumes only one byte per clock. A single scanner would therefore fall behind by a factor of four. The dispatcher makes up the difference by steering each complete packet to one scanner. It chooses among the scanners in rotating order and skips any that are still occupied. Several scanners can then receive, search and emit at the same time.

The ingress side picks a scanner when a packet's first word is accepted and keeps that choice until the last word. It applies backpressure to the source only when no scanner can take a new packet. The egress side merges the scanners' result streams onto one 32-bit bus. It grants one whole packet at a time, rotating among the scanners that have a packet ready. Packets may leave in a different order from the one in which they arrived. Each packet stays contiguous and intact.

Top module: `pkt_rr_dispatch`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and every `eng_wr_en` bit are 0, and `in_ready` is 1 whenever at least one `eng_free` bit is 1. The rotation pointers of both sides start at scanner 0.
- R2: Every accepted word of a packet is written to the one scanner chosen at its first word. The write appears as a single `eng_wr_en` bit, one cycle after acceptance, with the word's data and its start/end flags unchanged.
- R3: A new packet goes to the first available scanner found by searching upward with wrap-around. The search starts at the scanner one above the one that took the previous packet (scanner 0 after reset).
- R4: A scanner counts as available when its `eng_free` is 1 and it was not chosen in either of the two preceding cycles.
- R5: Between packets, `in_ready` equals "some scanner is available"; inside a packet, `in_ready` is 1. A cycle with `in_valid` high and `in_ready` low causes no scanner write.
- R6: A word accepted between packets without its start flag (`in_sof` = 0) is discarded and written to no scanner.
- R7: The output grant (`eng_out_ack`) goes to the first scanner with a valid start-of-packet word. The search starts one above the scanner granted last and wraps around. The grant is held until that scanner's end-of-packet word is taken. The acked word appears on `out_*` in the next cycle.
- R8: The output never interleaves packets: after a word without `out_eof`, no word with `out_sof` follows until the packet ends. Every packet sent in is delivered exactly once, as a multiset, with its words in order.
- R9: A packet of one word (start and end flags together) occupies a scanner for just that word on the input. It is granted for just that word on the output, and the lock is not left set on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Input word is the first of a packet |
| in_eof | input | 1 | Input word is the last of a packet |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted this cycle when high with `in_valid` |
| eng_free | input | 4 | Per scanner: idle and able to take a new packet |
| eng_wr_en | output | 4 | Per scanner write strobe, at most one high |
| eng_wr_sof | output | 1 | Start flag of the written word |
| eng_wr_eof | output | 1 | End flag of the written word |
| eng_wr_data | output | 32 | Written word, shared by all scanners |
| eng_out_valid | input | 4 | Per scanner: a result word is presented |
| eng_out_sof | input | 4 | Per scanner: presented word starts a packet |
| eng_out_eof | input | 4 | Per scanner: presented word ends a packet |
| eng_out_data | input | 128 | Presented words, scanner i in bits [32i+31:32i] |
| eng_out_ack | output | 4 | Per scanner: presented word taken this cycle |
| out_valid | output | 1 | Merged output word present |
| out_sof | output | 1 | Merged word starts a packet |
| out_eof | output | 1 | Merged word ends a packet |
| out_data | output | 32 | Merged output word |

## Verification
Ingress selection and scanner release can fall in the same cycle. A scanner may drop `eng_free` just as a new packet's first word arrives. Back-to-back one-word packets also make a selection in the cycle right after another, while the scanner just chosen still reports free. Bursts of single-word packets and random gaps provoke both cases. An independent model of R3/R4 predicts the chosen scanner in every such cycle. On the output side, one scanner's grant can end in the same cycle that another scanner presents a fresh start word. The bench judges that case by predicting every `eng_out_ack` from the rotation rule. It also checks that each packet's words come out contiguous and in order.

// File: rtl/pkt_rr_pkg.sv
// Shared types for the packet dispatcher.
// Assumes a fixed word width for all scanners and the input bus.
package pkt_rr_pkg;

    parameter int WORD_W = 32;

    // One bus word with its framing flags.
    typedef struct packed {
        logic              sof;
        logic              eof;
        logic [WORD_W-1:0] data;
    } word_t;

    // Next index in a ring of n entries.
    function automatic int wrap_inc(input int i, input int n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/rr_pick.sv
// Rotating first-set finder: returns the first asserted request
// at or above ptr, wrapping past the top. Purely combinational.
// Assumes ptr < N.
module rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Scan the ring once starting at ptr; first hit wins.
    always_comb begin
        int j;
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            j = (int'(ptr) + k) % N;
            if (!any && req[j]) begin
                any    = 1'b1;
                gnt[j] = 1'b1;
                idx    = IW'(j);
            end
        end
    end

endmodule

// File: rtl/ingress_steer.sv
// Ingress steering: picks a scanner at each packet's first word and
// forwards every word of that packet to it, one cycle after acceptance.
// Assumes a scanner drops eng_free no later than two cycles after the
// cycle it was chosen; a short mask covers that gap.
module ingress_steer
    import pkt_rr_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  word_t        in_word,
    output logic         in_ready,
    input  logic [N-1:0] eng_free,
    output logic [N-1:0] eng_wr_en,
    output word_t        eng_wr_word
);

    logic          busy_q;
    logic [IW-1:0] sel_q, ptr_q;
    logic [N-1:0]  claim_q, claim2_q, wr_en_q;
    word_t         wr_q;

    logic [N-1:0]  avail, pick_gnt;
    logic [IW-1:0] pick_idx;
    logic          pick_any, acc, start, cont;

    // Scanners that are free and not just handed a packet.
    assign avail = eng_free & ~claim_q & ~claim2_q;

    rr_pick #(.N(N), .IW(IW)) u_pick (
        .req (avail),
        .ptr (ptr_q),
        .gnt (pick_gnt),
        .idx (pick_idx),
        .any (pick_any)
    );

    // Handshake and packet boundary decode.
    always_comb begin
        in_ready = busy_q | pick_any;
        acc      = in_valid & in_ready;
        start    = acc & ~busy_q & in_word.sof;
        cont     = acc & busy_q;
    end

    // Steering state, selection mask and registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            sel_q    <= '0;
            ptr_q    <= '0;
            claim_q  <= '0;
            claim2_q <= '0;
            wr_en_q  <= '0;
            wr_q     <= '0;
        end else begin
            claim_q  <= start ? pick_gnt : '0;
            claim2_q <= claim_q;
            if (start) begin
                sel_q  <= pick_idx;
                ptr_q  <= IW'(wrap_inc(int'(pick_idx), N));
                busy_q <= ~in_word.eof;
            end else if (cont && in_word.eof) begin
                busy_q <= 1'b0;
            end
            if (start)
                wr_en_q <= pick_gnt;
            else if (cont)
                wr_en_q <= N'(1) << sel_q;
            else
                wr_en_q <= '0;
            if (acc)
                wr_q <= in_word;
        end
    end

    assign eng_wr_en   = wr_en_q;
    assign eng_wr_word = wr_q;

    // R2: a word goes to at most one scanner.
    p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_wr_en));

    // R2: a packet's next written word targets the same scanner.
    p_same_eng_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_wr_en && !eng_wr_word.eof) |=>
            (eng_wr_en == '0 || eng_wr_en == $past(eng_wr_en)));

    // R4: a first word only reaches a scanner that reported free.
    p_sof_to_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_wr_en && eng_wr_word.sof) |-> (($past(eng_free) & eng_wr_en) != '0));

    // R5: a stalled input cycle writes nothing.
    p_stall_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (eng_wr_en == '0));

endmodule

// File: rtl/egress_merge.sv
// Egress merge: rotating grant over scanners with a packet start ready,
// held for the whole packet; acked word is registered onto the output.
// Assumes a scanner shows its next word in the cycle after an ack.
module egress_merge
    import pkt_rr_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        eng_out_valid,
    input  logic [N-1:0]        eng_out_sof,
    input  logic [N-1:0]        eng_out_eof,
    input  logic [N*WORD_W-1:0] eng_out_data,
    output logic [N-1:0]        eng_out_ack,
    output logic                out_valid,
    output word_t               out_word
);

    logic          locked_q, out_v_q;
    logic [IW-1:0] gsel_q, optr_q;
    word_t         out_q;

    logic [N-1:0]  start_req, p_gnt;
    logic [IW-1:0] p_idx, cur;
    logic          p_any, go;
    word_t         cur_word;

    assign start_req = eng_out_valid & eng_out_sof;

    rr_pick #(.N(N), .IW(IW)) u_pick (
        .req (start_req),
        .ptr (optr_q),
        .gnt (p_gnt),
        .idx (p_idx),
        .any (p_any)
    );

    // Current grant, ack strobe and selected word.
    always_comb begin
        cur          = locked_q ? gsel_q : p_idx;
        go           = locked_q ? eng_out_valid[gsel_q] : p_any;
        eng_out_ack  = go ? (N'(1) << cur) : '0;
        cur_word.sof  = eng_out_sof[cur];
        cur_word.eof  = eng_out_eof[cur];
        cur_word.data = eng_out_data[int'(cur)*WORD_W +: WORD_W];
    end

    // Grant lock, rotation pointer and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            gsel_q   <= '0;
            optr_q   <= '0;
            out_v_q  <= 1'b0;
            out_q    <= '0;
        end else begin
            out_v_q <= go;
            if (go)
                out_q <= cur_word;
            if (go && !locked_q) begin
                gsel_q   <= p_idx;
                optr_q   <= IW'(wrap_inc(int'(p_idx), N));
                locked_q <= ~cur_word.eof;
            end else if (go && cur_word.eof) begin
                locked_q <= 1'b0;
            end
        end
    end

    assign out_valid = out_v_q;
    assign out_word  = out_q;

    // R7: at most one scanner acked, and only one that presents a word.
    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_out_ack) && ((eng_out_ack & ~eng_out_valid) == '0));

    // R7: an acked word shows up on the output next cycle.
    p_ack_to_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_out_ack) |=> out_valid);

    // R7: no ack, no output word next cycle.
    p_idle_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|eng_out_ack) |=> !out_valid);

    // R8: an open packet is never followed by another packet's start.
    p_no_interleave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_word.eof) |=> !(out_valid && out_word.sof));

endmodule

// File: rtl/pkt_rr_dispatch.sv
// Top of the dispatcher: spreads whole packets over N byte-serial
// scanners in rotating order and merges their results back onto one bus.
// Assumes well-formed packets on both sides (start flag first, end flag last).
module pkt_rr_dispatch
    import pkt_rr_pkg::*;
#(
    parameter int N_ENG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic [WORD_W-1:0]       in_data,
    output logic                    in_ready,
    input  logic [N_ENG-1:0]        eng_free,
    output logic [N_ENG-1:0]        eng_wr_en,
    output logic                    eng_wr_sof,
    output logic                    eng_wr_eof,
    output logic [WORD_W-1:0]       eng_wr_data,
    input  logic [N_ENG-1:0]        eng_out_valid,
    input  logic [N_ENG-1:0]        eng_out_sof,
    input  logic [N_ENG-1:0]        eng_out_eof,
    input  logic [N_ENG*WORD_W-1:0] eng_out_data,
    output logic [N_ENG-1:0]        eng_out_ack,
    output logic                    out_valid,
    output logic                    out_sof,
    output logic                    out_eof,
    output logic [WORD_W-1:0]       out_data
);

    localparam int IW = (N_ENG > 1) ? $clog2(N_ENG) : 1;

    word_t in_word, wr_word, o_word;

    assign in_word = '{sof: in_sof, eof: in_eof, data: in_data};

    ingress_steer #(.N(N_ENG), .IW(IW)) u_ingress (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .in_ready    (in_ready),
        .eng_free    (eng_free),
        .eng_wr_en   (eng_wr_en),
        .eng_wr_word (wr_word)
    );

    egress_merge #(.N(N_ENG), .IW(IW)) u_egress (
        .clk           (clk),
        .rst_n         (rst_n),
        .eng_out_valid (eng_out_valid),
        .eng_out_sof   (eng_out_sof),
        .eng_out_eof   (eng_out_eof),
        .eng_out_data  (eng_out_data),
        .eng_out_ack   (eng_out_ack),
        .out_valid     (out_valid),
        .out_word      (o_word)
    );

    assign eng_wr_sof  = wr_word.sof;
    assign eng_wr_eof  = wr_word.eof;
    assign eng_wr_data = wr_word.data;
    assign out_sof     = o_word.sof;
    assign out_eof     = o_word.eof;
    assign out_data    = o_word.data;

endmodule

// File: tb/sim_pkt_rr_dispatch.sv
// Bench: four byte-serial scanner stubs (4 cycles per word), directed
// corner cases plus seeded random packets; per-cycle prediction of
// routing and output grants, and multiset delivery check at the end.
module sim_pkt_rr_dispatch;

    localparam int N    = 4;
    localparam int W    = 32;
    localparam int NPKT = 207;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic           in_valid, in_sof, in_eof, in_ready;
    logic [W-1:0]   in_data;
    logic [N-1:0]   eng_free, eng_wr_en, eng_out_valid, eng_out_sof, eng_out_eof, eng_out_ack;
    logic           eng_wr_sof, eng_wr_eof;
    logic [W-1:0]   eng_wr_data;
    logic [N*W-1:0] eng_out_data;
    logic           out_valid, out_sof, out_eof;
    logic [W-1:0]   out_data;

    pkt_rr_dispatch #(.N_ENG(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .eng_free(eng_free), .eng_wr_en(eng_wr_en),
        .eng_wr_sof(eng_wr_sof), .eng_wr_eof(eng_wr_eof), .eng_wr_data(eng_wr_data),
        .eng_out_valid(eng_out_valid), .eng_out_sof(eng_out_sof),
        .eng_out_eof(eng_out_eof), .eng_out_data(eng_out_data),
        .eng_out_ack(eng_out_ack), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_data(out_data)
    );

    // ---------------- scanner stubs ----------------
    typedef enum logic [1:0] {S_FREE, S_RX, S_SCAN, S_TX} st_t;
    st_t         st  [N];
    logic [W-1:0] mem [N][16];
    int          wp [N], rp [N], ln [N], tmr [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                st[i] <= S_FREE; wp[i] <= 0; rp[i] <= 0; ln[i] <= 1; tmr[i] <= 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                case (st[i])
                    S_FREE: if (eng_wr_en[i] && eng_wr_sof) begin
                        mem[i][0] <= eng_wr_data; wp[i] <= 1; rp[i] <= 0;
                        if (eng_wr_eof) begin ln[i] <= 1; tmr[i] <= 4; st[i] <= S_SCAN; end
                        else st[i] <= S_RX;
                    end
                    S_RX: if (eng_wr_en[i]) begin
                        mem[i][wp[i] % 16] <= eng_wr_data; wp[i] <= wp[i] + 1;
                        if (eng_wr_eof) begin
                            ln[i] <= wp[i] + 1; tmr[i] <= 4 * (wp[i] + 1); st[i] <= S_SCAN;
                        end
                    end
                    S_SCAN: if (tmr[i] <= 1) st[i] <= S_TX; else tmr[i] <= tmr[i] - 1;
                    S_TX: if (eng_out_ack[i]) begin
                        if (rp[i] == ln[i] - 1) st[i] <= S_FREE;
                        rp[i] <= rp[i] + 1;
                    end
                    default: st[i] <= S_FREE;
                endcase
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            eng_free[i]           = (st[i] == S_FREE);
            eng_out_valid[i]      = (st[i] == S_TX);
            eng_out_sof[i]        = (rp[i] == 0);
            eng_out_eof[i]        = (rp[i] == ln[i] - 1);
            eng_out_data[i*W +: W] = mem[i][rp[i] % 16];
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0, stalls = 0;
    bit done = 1'b0;
    int delivered [int];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pick(input logic [N-1:0] req, input int ptr);
        for (int k = 0; k < N; k++)
            if (req[(ptr + k) % N]) return (ptr + k) % N;
        return -1;
    endfunction

    // model state
    bit           m_mid, m_olock, d_in, exp_ov, exp_osof, exp_oeof, exp_wsof, exp_weof;
    int           m_cur, m_ptr, m_og, m_optr, d_id, d_next;
    logic [N-1:0] c1, c2, exp_wr, exp_ack;
    logic [W-1:0] exp_wdata, exp_odata;

    always @(negedge clk) begin
        #2;
        if (!rst_n) begin
            m_mid = 0; m_olock = 0; d_in = 0; exp_ov = 0; m_cur = 0; m_ptr = 0;
            m_og = 0; m_optr = 0; c1 = '0; c2 = '0; exp_wr = '0;
        end else begin : mon
            logic [N-1:0] avail, newc;
            int e;
            // results of the previous cycle's decisions
            chk(eng_wr_en == exp_wr, "R3", "scanner write strobe", 64'(eng_wr_en), 64'(exp_wr));
            if (exp_wr != '0) begin
                chk(eng_wr_data == exp_wdata, "R2", "written data", 64'(eng_wr_data), 64'(exp_wdata));
                chk({eng_wr_sof, eng_wr_eof} == {exp_wsof, exp_weof}, "R2", "written flags",
                    64'({eng_wr_sof, eng_wr_eof}), 64'({exp_wsof, exp_weof}));
            end
            chk(out_valid == exp_ov, "R7", "out_valid", 64'(out_valid), 64'(exp_ov));
            if (exp_ov)
                chk({out_sof, out_eof, out_data} == {exp_osof, exp_oeof, exp_odata}, "R7",
                    "output word", 64'({out_sof, out_eof, out_data}), 64'({exp_osof, exp_oeof, exp_odata}));
            // ingress model (R3, R4, R5, R6)
            avail = eng_free & ~c1 & ~c2;
            if (in_valid) begin
                chk(in_ready == (m_mid ? 1'b1 : |avail), "R5", "in_ready",
                    64'(in_ready), 64'(m_mid ? 1'b1 : |avail));
                if (!in_ready) stalls++;
            end
            newc = '0; exp_wr = '0;
            if (in_valid && in_ready) begin
                exp_wdata = in_data; exp_wsof = in_sof; exp_weof = in_eof;
                if (m_mid) begin
                    exp_wr = N'(1) << m_cur;
                    if (in_eof) m_mid = 0;
                end else if (in_sof) begin
                    e = pick(avail, m_ptr);
                    if (e >= 0) begin
                        exp_wr = N'(1) << e; newc = N'(1) << e;
                        m_cur = e; m_ptr = (e + 1) % N; m_mid = !in_eof;
                    end
                end
                // else: stray word, R6 expects no write
            end
            c2 = c1; c1 = newc;
            // egress model (R7)
            exp_ack = '0;
            if (m_olock) begin
                if (eng_out_valid[m_og]) exp_ack = N'(1) << m_og;
            end else begin
                e = pick(eng_out_valid & eng_out_sof, m_optr);
                if (e >= 0) exp_ack = N'(1) << e;
            end
            chk(eng_out_ack == exp_ack, "R7", "output grant", 64'(eng_out_ack), 64'(exp_ack));
            exp_ov = 0;
            for (int g = 0; g < N; g++) begin
                if (exp_ack[g]) begin
                    exp_ov = 1; exp_osof = eng_out_sof[g]; exp_oeof = eng_out_eof[g];
                    exp_odata = eng_out_data[g*W +: W];
                    if (!m_olock) begin
                        m_optr = (g + 1) % N; m_og = g; m_olock = !eng_out_eof[g];
                    end else if (eng_out_eof[g]) m_olock = 0;
                end
            end
            // packet integrity on the merged bus (R8)
            if (out_valid) begin
                if (out_sof) begin
                    chk(!d_in, "R8", "start inside open packet", 64'(d_in), 64'(0));
                    d_in = 1; d_id = int'(out_data[31:16]); d_next = 0;
                end
                chk(int'(out_data[31:16]) == d_id && int'(out_data[15:8]) == d_next, "R8",
                    "word order", 64'(out_data[31:8]), 64'({d_id[15:0], d_next[7:0]}));
                chk(out_eof == (int'(out_data[15:8]) == int'(out_data[7:0]) - 1), "R8",
                    "end flag position", 64'(out_eof), 64'(int'(out_data[15:8]) == int'(out_data[7:0]) - 1));
                d_next++;
                if (out_eof) begin
                    d_in = 0;
                    if (delivered.exists(d_id)) delivered[d_id]++; else delivered[d_id] = 1;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_word(input logic s, input logic e, input logic [W-1:0] d);
        in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send_pkt(input int id, input int len);
        for (int i = 0; i < len; i++)
            send_word(i == 0, i == len - 1, {id[15:0], i[7:0], len[7:0]});
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'(0));
        chk(eng_wr_en == '0, "R1", "eng_wr_en after reset", 64'(eng_wr_en), 64'(0));
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'(1));
        @(negedge clk);
        // R6: stray word between packets is dropped (monitor expects no write)
        send_word(1'b0, 1'b0, 32'hFFFF_0001);
        #3;
        chk(eng_wr_en == '0, "R6", "write after stray word", 64'(eng_wr_en), 64'(0));
        @(negedge clk);
        // R9 / R5: burst of single-word packets overruns the four scanners
        for (int p = 0; p < 6; p++) send_pkt(p, 1);
        chk(stalls > 0, "R5", "backpressure seen in burst", 64'(stalls), 64'(1));
        // long packet
        send_pkt(6, 12);
        // random traffic
        for (int p = 7; p < NPKT; p++) begin
            send_pkt(p, 1 + int'($urandom % 12));
            repeat (int'($urandom % 4)) @(negedge clk);
        end
        repeat (400) @(negedge clk);
        // R8 / R9: multiset delivery
        for (int p = 0; p < NPKT; p++) begin
            if (p < 6)
                chk(delivered.exists(p) && delivered[p] == 1, "R9", "single-word packet delivered once",
                    64'(delivered.exists(p) ? delivered[p] : 0), 64'(1));
            else
                chk(delivered.exists(p) && delivered[p] == 1, "R8", "packet delivered once",
                    64'(delivered.exists(p) ? delivered[p] : 0), 64'(1));
        end
        chk(!delivered.exists(16'hFFFF), "R6", "stray word never delivered",
            64'(delivered.exists(16'hFFFF)), 64'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule